// File: doc/BRIEF.md
# Periodic Audio Sample Streaming DMA

This block streams audio samples from memory to one of two audio target ports. A free-running 128-cycle frame counter sets the timing. A rate divider counts whole frames and raises a transfer request at one of four sample rates. The request waits until the next bus-steal window, which covers frame positions 117 to 123. In that window the block reads one byte from the current source address. It then writes the byte, or zero while holding, to the selected target through a one-cycle strobe.

Software programs three registers: a 20-bit source address, a 20-bit byte length and an 8-bit control word. Writing the address or the length also stores the value in a shadow copy. In repeat mode the counters reload from these shadow copies when the length runs out. The counters change while playback runs and can be read back at any time. A write to the address or the length takes effect on the next transfer. A slow memory stretches the window through a wait input. Synthesis of the audio itself happens elsewhere.

Top module: `snd_stream_dma`

## Requirements
- R1: With no wait states, each transfer holds `bus_steal` high for exactly 7 cycles, at frame positions 117 to 123. Every window starts at the same phase of the 128-cycle frame, and the target strobe occurs in the last cycle of the window.
- R2: Control bits [1:0] set the gap between transfers in frames: 0 gives 6 frames (768 cycles), 1 gives 4 frames (512 cycles), 2 gives 2 frames (256 cycles) and 3 gives 1 frame (128 cycles).
- R3: `wr_sel` and `rd_sel` select the register: 0 is the source address, 1 is the length and 2 is the control word. The control word has rate in bits [1:0], hold in bit 2, repeat in bit 3, target in bit 4, direction in bit 6 and enable in bit 7. Bit 5 always reads 0, and a read returns the register value one cycle after the write.
- R4: While hold (bit 2) is set, windows and memory reads still take place. The strobe carries `sample` = 0x00, and the address and length counters do not change.
- R5: With repeat (bit 3) set, the address and the length reload from their last-written values when the length reaches 0, and playback continues without a gap.
- R6: With repeat clear, the transfer that brings the length to 0 also clears enable (bit 7). No further window follows, the length reads 0 and the address reads the start address stepped by the original length.
- R7: Each transfer reads the byte at `mem_addr`, which equals the current address counter, and presents it on `sample`. The address then steps by +1 when direction (bit 6) is 0 and by -1 when it is 1, wrapping modulo 2^20.
- R8: Target bit 4 = 0 pulses `chan_wr` and target bit 4 = 1 pulses `voice_wr`. The two never pulse together.
- R9: Each cycle in which `mem_wait` is high while `mem_req` is high lengthens the window by one cycle. `mem_req` is only high inside a window.
- R10: The address and length counters can be read while playback runs. An address write made between transfers sets the address that the next transfer uses.
- R11: After reset, `bus_steal`, `mem_req`, `chan_wr` and `voice_wr` are low, and all three registers read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select for a write |
| wr_data | input | 20 | Register write data |
| rd_sel | input | 2 | Register select for a read |
| rd_data | output | 20 | Register read data |
| mem_req | output | 1 | Memory byte read request |
| mem_addr | output | 20 | Memory read address |
| mem_rdata | input | 8 | Memory read data |
| mem_wait | input | 1 | Memory not ready, stall the read |
| bus_steal | output | 1 | Bus cycles taken by the DMA |
| chan_wr | output | 1 | Write strobe to the channel sample port |
| voice_wr | output | 1 | Write strobe to the voice port |
| sample | output | 8 | Sample byte for the target |

## Verification
A register write is captured on one clock edge and reads back in the cycle that follows. A transfer strobe comes in the seventh cycle of its window, plus one cycle for each stalled read, and the counters show the new values in the cycle after the strobe. The bench therefore samples at falling edges. For each strobe it records the cycle index, the data and the target, and for each window its length and frame phase. It compares these records with sequences that bench functions compute from the requirements. It reads counters back only between transfers, well after the last update is due.

// File: rtl/snd_dma_pkg.sv
package snd_dma_pkg;

  localparam int DIV_W = 3;

  typedef enum logic [1:0] {
    SEL_ADDR = 2'd0,
    SEL_LEN  = 2'd1,
    SEL_CTRL = 2'd2
  } reg_sel_e;

  typedef struct packed {
    logic       en;
    logic       dir;
    logic       rsvd;
    logic       tgt;
    logic       rpt;
    logic       hold;
    logic [1:0] rate;
  } ctrl_t;

  // frames between transfers for each rate code
  function automatic logic [DIV_W-1:0] rate_div(input logic [1:0] code);
    case (code)
      2'd0:    rate_div = 3'd6;
      2'd1:    rate_div = 3'd4;
      2'd2:    rate_div = 3'd2;
      default: rate_div = 3'd1;
    endcase
  endfunction

endpackage

// File: rtl/snd_dma_timer.sv
module snd_dma_timer
  import snd_dma_pkg::*;
#(
  parameter int FRAME_LEN = 128,
  parameter int WIN_START = 117,
  localparam int FW = $clog2(FRAME_LEN)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic [1:0]    rate,
  input  logic          busy,
  output logic          start,
  output logic [FW-1:0] frame
);

  localparam logic [FW-1:0] LAST_POS = FW'(FRAME_LEN - 1);
  localparam logic [FW-1:0] PRE_WIN  = FW'(WIN_START - 1);

  logic [FW-1:0]    frame_q, frame_d;
  logic [DIV_W-1:0] div_q, div_d;
  logic             pend_q, pend_d;
  logic             frame_end, tick;

  always_comb begin
    frame_end = (frame_q == LAST_POS);
    frame_d   = frame_end ? '0 : frame_q + 1'b1;
    tick      = en && frame_end && (div_q >= rate_div(rate) - 1'b1);
    start     = en && pend_q && !busy && (frame_q == PRE_WIN);

    div_d = div_q;
    if (!en)            div_d = '0;
    else if (tick)      div_d = '0;
    else if (frame_end) div_d = div_q + 1'b1;

    pend_d = pend_q;
    if (!en)        pend_d = 1'b0;
    else if (tick)  pend_d = 1'b1;
    else if (start) pend_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frame_q <= '0;
      div_q   <= '0;
      pend_q  <= 1'b0;
    end else begin
      frame_q <= frame_d;
      div_q   <= div_d;
      pend_q  <= pend_d;
    end
  end

  assign frame = frame_q;

endmodule

// File: rtl/snd_dma_xfer.sv
module snd_dma_xfer #(
  parameter int DATA_W   = 8,
  parameter int WIN_LEN  = 7,
  parameter int MEM_STEP = 3,
  localparam int SW = $clog2(WIN_LEN)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              mem_wait,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic              hold,
  input  logic              tgt,
  output logic              busy,
  output logic              mem_req,
  output logic              done,
  output logic              chan_wr,
  output logic              voice_wr,
  output logic [DATA_W-1:0] sample
);

  localparam logic [SW-1:0] LAST_STEP = SW'(WIN_LEN - 1);
  localparam logic [SW-1:0] RD_STEP   = SW'(MEM_STEP);

  logic [SW-1:0]     step_q, step_d;
  logic              busy_q, busy_d;
  logic [DATA_W-1:0] data_q, data_d;
  logic              last, stall, rd_ok;

  always_comb begin
    last    = busy_q && (step_q == LAST_STEP);
    mem_req = busy_q && (step_q == RD_STEP);
    stall   = mem_req && mem_wait;
    rd_ok   = mem_req && !mem_wait;

    busy_d = busy_q;
    if (start)     busy_d = 1'b1;
    else if (last) busy_d = 1'b0;

    step_d = step_q;
    if (start || last)        step_d = '0;
    else if (busy_q && !stall) step_d = step_q + 1'b1;

    data_d = rd_ok ? mem_rdata : data_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      step_q <= '0;
      busy_q <= 1'b0;
      data_q <= '0;
    end else begin
      step_q <= step_d;
      busy_q <= busy_d;
      data_q <= data_d;
    end
  end

  assign busy     = busy_q;
  assign done     = last;
  assign chan_wr  = last && !tgt;
  assign voice_wr = last && tgt;
  assign sample   = hold ? '0 : data_q;

endmodule

// File: rtl/snd_dma_regs.sv
module snd_dma_regs
  import snd_dma_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int LEN_W  = 20,
  parameter int REG_W  = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        wr_sel,
  input  logic [REG_W-1:0]  wr_data,
  input  logic [1:0]        rd_sel,
  output logic [REG_W-1:0]  rd_data,
  input  logic              done,
  output logic [ADDR_W-1:0] addr,
  output logic [LEN_W-1:0]  len,
  output ctrl_t             ctrl
);

  logic [ADDR_W-1:0] addr_q, addr_d, sh_addr_q, sh_addr_d, addr_step;
  logic [LEN_W-1:0]  len_q, len_d, sh_len_q, sh_len_d, len_dec;
  ctrl_t             ctrl_q, ctrl_d;
  logic              advance, at_end;

  always_comb begin
    addr_step = ctrl_q.dir ? addr_q - 1'b1 : addr_q + 1'b1;
    len_dec   = (len_q == '0) ? '0 : len_q - 1'b1;
    at_end    = (len_dec == '0);
    advance   = done && !ctrl_q.hold;

    addr_d    = addr_q;
    len_d     = len_q;
    ctrl_d    = ctrl_q;
    sh_addr_d = sh_addr_q;
    sh_len_d  = sh_len_q;

    if (advance) begin
      if (at_end && ctrl_q.rpt) begin
        addr_d = sh_addr_q;
        len_d  = sh_len_q;
      end else begin
        addr_d = addr_step;
        len_d  = len_dec;
        if (at_end) ctrl_d.en = 1'b0;
      end
    end

    // a software write in the same cycle takes priority
    if (wr_en) begin
      case (reg_sel_e'(wr_sel))
        SEL_ADDR: begin
          addr_d    = wr_data[ADDR_W-1:0];
          sh_addr_d = wr_data[ADDR_W-1:0];
        end
        SEL_LEN: begin
          len_d    = wr_data[LEN_W-1:0];
          sh_len_d = wr_data[LEN_W-1:0];
        end
        SEL_CTRL: begin
          ctrl_d      = ctrl_t'(wr_data[7:0]);
          ctrl_d.rsvd = 1'b0;
        end
        default: ;
      endcase
    end

    case (reg_sel_e'(rd_sel))
      SEL_ADDR: rd_data = REG_W'(addr_q);
      SEL_LEN:  rd_data = REG_W'(len_q);
      SEL_CTRL: rd_data = REG_W'(ctrl_q);
      default:  rd_data = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q    <= '0;
      len_q     <= '0;
      ctrl_q    <= '0;
      sh_addr_q <= '0;
      sh_len_q  <= '0;
    end else begin
      addr_q    <= addr_d;
      len_q     <= len_d;
      ctrl_q    <= ctrl_d;
      sh_addr_q <= sh_addr_d;
      sh_len_q  <= sh_len_d;
    end
  end

  assign addr = addr_q;
  assign len  = len_q;
  assign ctrl = ctrl_q;

endmodule

// File: rtl/snd_stream_dma.sv
module snd_stream_dma
  import snd_dma_pkg::*;
#(
  parameter int ADDR_W    = 20,
  parameter int LEN_W     = 20,
  parameter int REG_W     = 20,
  parameter int DATA_W    = 8,
  parameter int FRAME_LEN = 128,
  parameter int WIN_START = 117,
  parameter int WIN_LEN   = 7,
  parameter int MEM_STEP  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        wr_sel,
  input  logic [REG_W-1:0]  wr_data,
  input  logic [1:0]        rd_sel,
  output logic [REG_W-1:0]  rd_data,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic              mem_wait,
  output logic              bus_steal,
  output logic              chan_wr,
  output logic              voice_wr,
  output logic [DATA_W-1:0] sample
);

  localparam int FW = $clog2(FRAME_LEN);

  logic [1:0]        rs_q;
  logic              rst_q;
  logic              start, busy, done;
  logic [FW-1:0]     frame_q;
  logic [ADDR_W-1:0] addr_q;
  logic [LEN_W-1:0]  len_q;
  ctrl_t             ctrl_q;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_q = rs_q[1];

  snd_dma_regs #(
    .ADDR_W(ADDR_W), .LEN_W(LEN_W), .REG_W(REG_W)
  ) u_regs (
    .clk(clk), .rst_n(rst_q),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .rd_sel(rd_sel), .rd_data(rd_data),
    .done(done), .addr(addr_q), .len(len_q), .ctrl(ctrl_q)
  );

  snd_dma_timer #(
    .FRAME_LEN(FRAME_LEN), .WIN_START(WIN_START)
  ) u_timer (
    .clk(clk), .rst_n(rst_q),
    .en(ctrl_q.en), .rate(ctrl_q.rate), .busy(busy),
    .start(start), .frame(frame_q)
  );

  snd_dma_xfer #(
    .DATA_W(DATA_W), .WIN_LEN(WIN_LEN), .MEM_STEP(MEM_STEP)
  ) u_xfer (
    .clk(clk), .rst_n(rst_q),
    .start(start), .mem_wait(mem_wait), .mem_rdata(mem_rdata),
    .hold(ctrl_q.hold), .tgt(ctrl_q.tgt),
    .busy(busy), .mem_req(mem_req), .done(done),
    .chan_wr(chan_wr), .voice_wr(voice_wr), .sample(sample)
  );

  assign bus_steal = busy;
  assign mem_addr  = addr_q;

endmodule

// File: rtl/snd_stream_dma_sva.sv
module snd_stream_dma_sva #(
  parameter int FW        = 7,
  parameter int WIN_START = 117,
  parameter int DATA_W    = 8,
  parameter int ADDR_W    = 20
) (
  input logic              clk,
  input logic              rst_n,
  input logic [FW-1:0]     frame,
  input logic              bus_steal,
  input logic              mem_req,
  input logic              chan_wr,
  input logic              voice_wr,
  input logic [DATA_W-1:0] sample,
  input logic              hold,
  input logic [ADDR_W-1:0] addr,
  input logic              wr_en
);

  p_window_start_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_steal) |-> frame == FW'(WIN_START));

  p_strobe_in_window_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (chan_wr || voice_wr) |-> bus_steal);

  p_one_target_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({chan_wr, voice_wr}));

  p_hold_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (hold && (chan_wr || voice_wr)) |-> sample == '0);

  p_hold_freeze_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (hold && !wr_en) |=> $stable(addr));

  p_req_in_window_r9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> bus_steal);

endmodule

bind snd_stream_dma snd_stream_dma_sva #(
  .FW(FW), .WIN_START(WIN_START), .DATA_W(DATA_W), .ADDR_W(ADDR_W)
) u_sva (
  .clk(clk), .rst_n(rst_q), .frame(frame_q),
  .bus_steal(bus_steal), .mem_req(mem_req),
  .chan_wr(chan_wr), .voice_wr(voice_wr), .sample(sample),
  .hold(ctrl_q.hold), .addr(addr_q), .wr_en(wr_en)
);

// File: tb/snd_stream_dma_tb.sv
module snd_stream_dma_tb;

  logic        clk;
  logic        rst_n;
  logic        wr_en;
  logic [1:0]  wr_sel;
  logic [19:0] wr_data;
  logic [1:0]  rd_sel;
  logic [19:0] rd_data;
  logic        mem_req;
  logic [19:0] mem_addr;
  logic [7:0]  mem_rdata;
  logic        mem_wait;
  logic        bus_steal, chan_wr, voice_wr;
  logic [7:0]  sample;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int waits = 0;
  int wcnt = 0;
  int exp_win = 7;
  int steal_run = 0;
  int ref_phase = -1;
  int ev_n = 0;
  int ev_time [64];
  logic [7:0] ev_data [64];
  bit ev_tgt [64];

  snd_stream_dma u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .rd_sel(rd_sel), .rd_data(rd_data), .mem_req(mem_req), .mem_addr(mem_addr),
    .mem_rdata(mem_rdata), .mem_wait(mem_wait), .bus_steal(bus_steal),
    .chan_wr(chan_wr), .voice_wr(voice_wr), .sample(sample)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  function automatic logic [7:0] mem_byte(input logic [19:0] a);
    return a[7:0] ^ a[15:8] ^ {4'h5, a[19:16]};
  endfunction

  assign mem_rdata = mem_byte(mem_addr);

  function automatic logic [19:0] exp_addr(input logic [19:0] a, input bit dir, input int idx);
    return dir ? a - 20'(idx) : a + 20'(idx);
  endfunction

  function automatic int frames_of(input int rate);
    case (rate)
      0: return 6;
      1: return 4;
      2: return 2;
      default: return 1;
    endcase
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // monitor, wait-state driver and watchdog
  always @(negedge clk) begin
    if (rst_n) begin
      cyc++;
      if (mem_req && wcnt < waits) begin
        mem_wait = 1'b1;
        wcnt++;
      end else begin
        mem_wait = 1'b0;
        if (!mem_req) wcnt = 0;
      end
      if (bus_steal) begin
        if (steal_run == 0) begin
          if (ref_phase < 0) ref_phase = cyc % 128;
          else chk((cyc % 128) == ref_phase, "R1 window phase", cyc % 128, ref_phase);
        end
        steal_run++;
      end else if (steal_run > 0) begin
        chk(steal_run == exp_win, "R1/R9 window length", steal_run, exp_win);
        steal_run = 0;
      end
      if ((chan_wr || voice_wr) && ev_n < 64) begin
        ev_time[ev_n] = cyc;
        ev_data[ev_n] = sample;
        ev_tgt[ev_n]  = voice_wr;
        ev_n++;
      end
      if (cyc > 150000) begin
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
      end
    end
  end

  task automatic reg_wr(input logic [1:0] sel, input logic [19:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic reg_rd(input logic [1:0] sel, output logic [19:0] d);
    @(negedge clk);
    rd_sel = sel;
    #1 d = rd_data;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_ev(input int n, input int limit);
    int t = 0;
    while (ev_n < n && t < limit) begin
      @(negedge clk);
      t++;
    end
  endtask

  function automatic logic [19:0] ctrl_word(input bit en, input bit dir, input bit tgt,
                                            input bit rpt, input bit hold, input int rate);
    return {12'd0, en, dir, 1'b0, tgt, rpt, hold, 2'(rate)};
  endfunction

  // compare recorded strobes against the expected sequence
  task automatic check_events(input logic [19:0] a, input int l, input int rate, input bit dir,
                              input bit tgt, input bit rpt, input bit hold, input int n);
    for (int k = 0; k < n; k++) begin
      int idx = hold ? 0 : (rpt ? k % l : k);
      logic [7:0] ed = hold ? 8'h00 : mem_byte(exp_addr(a, dir, idx));
      chk(ev_data[k] == ed, hold ? "R4 sample zero" : (rpt ? "R5 repeat data" : "R7 data"),
          ev_data[k], ed);
      chk(ev_tgt[k] == tgt, "R8 target strobe", ev_tgt[k], tgt);
      if (k > 0)
        chk(ev_time[k] - ev_time[k-1] == 128 * frames_of(rate), "R2 spacing",
            ev_time[k] - ev_time[k-1], 128 * frames_of(rate));
    end
  endtask

  task automatic one_shot(input logic [19:0] a, input int l, input int rate, input bit dir,
                          input bit tgt, input int w);
    logic [19:0] v;
    ev_n = 0; waits = w; exp_win = 7 + w;
    reg_wr(2'd0, a);
    reg_wr(2'd1, 20'(l));
    reg_wr(2'd2, ctrl_word(1, dir, tgt, 0, 0, rate));
    idle((l + 2) * 128 * frames_of(rate) + 300);
    chk(ev_n == l, "R6 transfer count", ev_n, l);
    check_events(a, l, rate, dir, tgt, 0, 0, l);
    reg_rd(2'd2, v);
    chk(v[7] == 1'b0, "R6 enable cleared", v[7], 0);
    reg_rd(2'd1, v);
    chk(v == 20'd0, "R6 length zero", v, 0);
    reg_rd(2'd0, v);
    chk(v == exp_addr(a, dir, l), "R7 final address", v, exp_addr(a, dir, l));
  endtask

  initial begin
    logic [19:0] v;
    void'($urandom(32'd2718));
    rst_n = 1'b0; wr_en = 1'b0; wr_sel = '0; wr_data = '0; rd_sel = '0; mem_wait = 1'b0;
    idle(4);
    rst_n = 1'b1;
    idle(4);

    // R11 reset state
    chk(!bus_steal && !mem_req, "R11 idle bus", {bus_steal, mem_req}, 0);
    chk(!chan_wr && !voice_wr, "R11 idle strobes", {chan_wr, voice_wr}, 0);
    for (int s = 0; s < 3; s++) begin
      reg_rd(2'(s), v);
      chk(v == 20'd0, "R11 register reset", v, 0);
    end

    // R3 register map and reserved bit
    reg_wr(2'd2, 20'h0007F);
    reg_rd(2'd2, v);
    chk(v == 20'h0005F, "R3 control readback", v, 20'h5F);
    reg_wr(2'd2, 20'h0);
    reg_wr(2'd0, 20'hABCDE);
    reg_rd(2'd0, v);
    chk(v == 20'hABCDE, "R3 address readback", v, 20'hABCDE);
    idle(200);
    chk(ev_n == 0, "R6 disabled gives no transfers", ev_n, 0);

    // directed cases
    one_shot(20'h00010, 3, 3, 0, 0, 0);     // R1 R7 fastest rate
    one_shot(20'h00001, 3, 1, 1, 1, 0);     // R7 decrement wraps below zero, R8 voice
    one_shot(20'h00200, 2, 3, 0, 0, 3);     // R9 wait states stretch window

    // R4 hold
    ev_n = 0; waits = 0; exp_win = 7;
    reg_wr(2'd0, 20'h00100);
    reg_wr(2'd1, 20'd5);
    reg_wr(2'd2, ctrl_word(1, 0, 0, 0, 1, 3));
    wait_ev(3, 2000);
    idle(20);
    reg_wr(2'd2, 20'h0);
    idle(300);
    check_events(20'h00100, 5, 3, 0, 0, 0, 1, 3);
    reg_rd(2'd0, v);
    chk(v == 20'h00100, "R4 address frozen", v, 20'h100);
    reg_rd(2'd1, v);
    chk(v == 20'd5, "R4 length frozen", v, 5);

    // R5 repeat
    ev_n = 0;
    reg_wr(2'd0, 20'h00020);
    reg_wr(2'd1, 20'd2);
    reg_wr(2'd2, ctrl_word(1, 0, 1, 1, 0, 2));
    wait_ev(5, 8000);
    idle(20);
    reg_wr(2'd2, 20'h0);
    idle(300);
    chk(ev_n >= 5, "R5 repeat continues", ev_n, 5);
    check_events(20'h00020, 2, 2, 0, 1, 1, 0, 5);

    // R10 live counters and mid-run address write
    ev_n = 0;
    reg_wr(2'd0, 20'h00040);
    reg_wr(2'd1, 20'd10);
    reg_wr(2'd2, ctrl_word(1, 0, 0, 0, 0, 3));
    wait_ev(2, 2000);
    idle(10);
    reg_rd(2'd1, v);
    chk(v == 20'd8, "R10 live length", v, 8);
    reg_rd(2'd0, v);
    chk(v == 20'h00042, "R10 live address", v, 20'h42);
    reg_wr(2'd0, 20'h00080);
    wait_ev(4, 2000);
    idle(10);
    reg_wr(2'd2, 20'h0);
    idle(300);
    chk(ev_data[2] == mem_byte(20'h00080), "R10 new address used", ev_data[2], mem_byte(20'h80));
    chk(ev_data[3] == mem_byte(20'h00081), "R10 address steps on", ev_data[3], mem_byte(20'h81));

    // constrained random one-shot runs
    for (int i = 0; i < 5; i++) begin
      logic [19:0] ra = 20'($urandom);
      int rl = 1 + int'($urandom % 3);
      int rr = int'($urandom % 4);
      bit rd = 1'($urandom);
      bit rt = 1'($urandom);
      int rw = int'($urandom % 3);
      one_shot(ra, rl, rr, rd, rt, rw);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule